// File: doc/BRIEF.md
# Memory Pattern Test Sequencer

This block is a self-contained test engine for a single-port synchronous RAM. A one-cycle start pulse selects one of nine fixed access patterns. The engine drives the RAM through that pattern by itself: ascending fills, solid and checkerboard fills, walking-bit fills, write/read interleaving, repeated writes, repeated reads, and a sweep limited to the top region of the address space. It predicts every value it reads back and compares each returned word against that prediction.

During a run, `busy` is high. The first mismatch sets a sticky fail flag and freezes a record of the failing address, the expected word and the word actually read. The run always continues to the end of the pattern. A single-cycle `done` then marks completion, and at that point the result outputs are final. An accepted start clears the previous result.

The RAM is assumed to return read data one cycle after the read strobe. The address and data widths and the size of the top region are parameters.

Top module: `mempat_engine`

## Requirements
- R1: After reset, `busy`, `done`, `failFlag` and `ramEn` are all low.
- R2: With `modeSel`=0 (ordered), every address 0..2^ADDR_W-1 is written in ascending order with data equal to its address, zero-extended or truncated to DATA_W. All addresses are then read back in ascending order and checked against the same value.
- R3: With `modeSel`=1, every location is written with all zeros and then read expecting all zeros. With `modeSel`=2, the same is done with all ones.
- R4: With `modeSel`=3 (checkerboard), even addresses receive all zeros and odd addresses receive all ones. The read pass expects the same parity pattern.
- R5: With `modeSel`=4 (interleaved), each address in ascending order is written with its address value, and the very next cycle reads that same address.
- R6: With `modeSel`=5 (double write), each address is written twice and then read once. The first write carries the bitwise inverse of the address value and the second carries the address value. The read expects the second value.
- R7: With `modeSel`=6 (double read), each address is written once with its address value and then read twice back to back. Both reads must return that value.
- R8: With `modeSel`=7 (boundary), only addresses whose top TOP_BITS bits are all ones are accessed. That region is written with address values in ascending order and then read back.
- R9: With `modeSel`=8 (walking), address a holds a one-hot word whose set bit is a mod DATA_W. The word is inverted, giving walking zeros, when address bit log2(DATA_W) is 1. A read pass checks every location.
- R10: Read data is compared in the cycle after each read strobe. The first mismatch sets `failFlag` and captures the address, expected word and actual word. Later mismatches change none of these until the next accepted start clears them.
- R11: `done` is high for exactly one cycle, with `busy` low, at the cycle after edge L counted from the start edge. L is 2N+2 for the two-pass modes (0,1,2,3,7,8 and 4), where N is the number of locations visited, and 3N+2 for modes 5 and 6.
- R12: `start` is ignored while a run is in progress, and also when `modeSel` is 9..15. The RAM is not enabled while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only while idle |
| modeSel | input | 4 | Pattern code 0..8 |
| ramAddr | output | ADDR_W | RAM address |
| ramWdata | output | DATA_W | RAM write data |
| ramEn | output | 1 | RAM access strobe |
| ramWr | output | 1 | 1 = write, 0 = read (valid with ramEn) |
| ramRdata | input | DATA_W | RAM read data, one cycle after a read strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| failFlag | output | 1 | Sticky mismatch flag |
| failAddr | output | ADDR_W | Address of the first mismatch |
| failExp | output | DATA_W | Expected word at the first mismatch |
| failAct | output | DATA_W | Word read at the first mismatch |

## Verification
The bench builds the engine with ADDR_W=6, DATA_W=8 and TOP_BITS=3. This gives 64 locations and an 8-word top region starting at 56, so every pattern finishes in under 200 cycles and the exact run lengths and access counts can be checked.

A data word wider than the address exercises zero extension. The 64 addresses span eight alternating walking-ones and walking-zeros groups.

The RAM model in the bench can force one data bit at one address, or at every address. This places the first mismatch at a known address with known expected and actual words. A fault placed outside the top region lets the bench show that boundary mode never reaches it.

// File: rtl/mempat_pkg.sv
package mempat_pkg;

  typedef enum logic [3:0] {
    MODE_ORDER  = 4'd0,
    MODE_ZERO   = 4'd1,
    MODE_ONES   = 4'd2,
    MODE_CHECK  = 4'd3,
    MODE_INTER  = 4'd4,
    MODE_DWRITE = 4'd5,
    MODE_DREAD  = 4'd6,
    MODE_EDGE   = 4'd7,
    MODE_WALK   = 4'd8
  } modeCode_t;

  localparam logic [3:0] MODE_MAX = 4'd8;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clrAddr;     // load start address
    logic regionBase;  // start address is the top region base
    logic incAddr;     // advance address
    logic doWrite;     // issue write
    logic doRead;      // issue read
    logic altData;     // write inverted pattern word
    logic clearFail;   // wipe result record
  } dpStrobe_t;

  function automatic logic isTwoPass(modeCode_t m);
    return !(m == MODE_INTER || m == MODE_DWRITE || m == MODE_DREAD);
  endfunction

endpackage

// File: rtl/mempat_ctrl.sv
module mempat_ctrl
  import mempat_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [3:0] modeSel,
  input  logic       lastAddr,
  output dpStrobe_t  strobe,
  output modeCode_t  activeMode,
  output logic       busy,
  output logic       done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WPASS, ST_RPASS, ST_STEP, ST_FLUSH, ST_FIN
  } ctrlState_t;

  ctrlState_t state;
  logic [1:0] stepCnt;
  logic       modeOk;
  logic       lastStep;
  modeCode_t  selMode;

  assign modeOk   = (modeSel <= MODE_MAX);
  assign selMode  = modeCode_t'(modeSel);
  assign lastStep = (activeMode == MODE_INTER) ? (stepCnt == 2'd1) : (stepCnt == 2'd2);

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE: begin
        if (start && modeOk) begin
          strobe.clrAddr    = 1'b1;
          strobe.regionBase = (selMode == MODE_EDGE);
          strobe.clearFail  = 1'b1;
        end
      end
      ST_WPASS: begin
        strobe.doWrite = 1'b1;
        if (lastAddr) begin
          strobe.clrAddr    = 1'b1;
          strobe.regionBase = (activeMode == MODE_EDGE);
        end else begin
          strobe.incAddr = 1'b1;
        end
      end
      ST_RPASS: begin
        strobe.doRead  = 1'b1;
        strobe.incAddr = !lastAddr;
      end
      ST_STEP: begin
        case (activeMode)
          MODE_INTER: begin
            strobe.doWrite = (stepCnt == 2'd0);
            strobe.doRead  = (stepCnt == 2'd1);
          end
          MODE_DWRITE: begin
            strobe.doWrite = (stepCnt != 2'd2);
            strobe.altData = (stepCnt == 2'd0);
            strobe.doRead  = (stepCnt == 2'd2);
          end
          default: begin
            strobe.doWrite = (stepCnt == 2'd0);
            strobe.doRead  = (stepCnt != 2'd0);
          end
        endcase
        strobe.incAddr = lastStep && !lastAddr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      stepCnt    <= 2'd0;
      activeMode <= MODE_ORDER;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start && modeOk) begin
            activeMode <= selMode;
            stepCnt    <= 2'd0;
            state      <= isTwoPass(selMode) ? ST_WPASS : ST_STEP;
          end
        end
        ST_WPASS: if (lastAddr) state <= ST_RPASS;
        ST_RPASS: if (lastAddr) state <= ST_FLUSH;
        ST_STEP: begin
          if (lastStep) begin
            stepCnt <= 2'd0;
            if (lastAddr) state <= ST_FLUSH;
          end else begin
            stepCnt <= stepCnt + 2'd1;
          end
        end
        ST_FLUSH: state <= ST_FIN;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_WPASS) || (state == ST_RPASS) ||
                (state == ST_STEP)  || (state == ST_FLUSH);
  assign done = (state == ST_FIN);

endmodule

// File: rtl/mempat_dpath.sv
module mempat_dpath
  import mempat_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int TOP_BITS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  modeCode_t         activeMode,
  output logic              lastAddr,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  output logic              ramEn,
  output logic              ramWr,
  output logic [DATA_W-1:0] readExp
);

  localparam int SEL_W = $clog2(DATA_W);
  localparam logic [ADDR_W-1:0] REGION_BASE =
    {{TOP_BITS{1'b1}}, {(ADDR_W-TOP_BITS){1'b0}}};

  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] addrAsData;
  logic [DATA_W-1:0] walkOnes;
  logic              walkFlip;
  logic [DATA_W-1:0] patWord;

  always_ff @(posedge clk) begin
    if (rst)                 addr <= '0;
    else if (strobe.clrAddr) addr <= strobe.regionBase ? REGION_BASE : '0;
    else if (strobe.incAddr) addr <= addr + 1'b1;
  end

  // address folded onto the data width
  generate
    if (DATA_W >= ADDR_W) begin : g_extend
      assign addrAsData = DATA_W'(addr);
    end else begin : g_trunc
      assign addrAsData = addr[DATA_W-1:0];
    end
    if (ADDR_W > SEL_W) begin : g_walkFlip
      assign walkFlip = addr[SEL_W];
    end else begin : g_noFlip
      assign walkFlip = 1'b0;
    end
  endgenerate

  assign walkOnes = DATA_W'(1) << addr[SEL_W-1:0];

  always_comb begin
    case (activeMode)
      MODE_ZERO:  patWord = '0;
      MODE_ONES:  patWord = '1;
      MODE_CHECK: patWord = {DATA_W{addr[0]}};
      MODE_WALK:  patWord = walkOnes ^ {DATA_W{walkFlip}};
      default:    patWord = addrAsData;
    endcase
  end

  assign lastAddr = &addr;
  assign ramAddr  = addr;
  assign ramWdata = patWord ^ {DATA_W{strobe.altData}};
  assign readExp  = patWord;
  assign ramEn    = strobe.doWrite | strobe.doRead;
  assign ramWr    = strobe.doWrite;

endmodule

// File: rtl/mempat_cmp.sv
module mempat_cmp #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clearFail,
  input  logic              readIssued,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] expIn,
  input  logic [DATA_W-1:0] rdata,
  output logic              failFlag,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failAct
);

  logic              chkValid;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] expQ;
  logic              mismatch;

  // expectation travels alongside the RAM's one-cycle read
  always_ff @(posedge clk) begin
    if (rst) begin
      chkValid <= 1'b0;
      addrQ    <= '0;
      expQ     <= '0;
    end else begin
      chkValid <= readIssued;
      addrQ    <= addrIn;
      expQ     <= expIn;
    end
  end

  assign mismatch = chkValid && (rdata != expQ);

  always_ff @(posedge clk) begin
    if (rst || clearFail) begin
      failFlag <= 1'b0;
      failAddr <= '0;
      failExp  <= '0;
      failAct  <= '0;
    end else if (mismatch && !failFlag) begin
      failFlag <= 1'b1;
      failAddr <= addrQ;
      failExp  <= expQ;
      failAct  <= rdata;
    end
  end

endmodule

// File: rtl/mempat_engine.sv
module mempat_engine
  import mempat_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int TOP_BITS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [3:0]        modeSel,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  output logic              ramEn,
  output logic              ramWr,
  input  logic [DATA_W-1:0] ramRdata,
  output logic              busy,
  output logic              done,
  output logic              failFlag,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failAct
);

  dpStrobe_t         strobe;
  modeCode_t         activeMode;
  logic              lastAddr;
  logic [DATA_W-1:0] readExp;

  mempat_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .modeSel(modeSel),
    .lastAddr(lastAddr), .strobe(strobe), .activeMode(activeMode),
    .busy(busy), .done(done)
  );

  mempat_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOP_BITS(TOP_BITS)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .activeMode(activeMode),
    .lastAddr(lastAddr), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .ramEn(ramEn), .ramWr(ramWr), .readExp(readExp)
  );

  mempat_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .clearFail(strobe.clearFail),
    .readIssued(strobe.doRead), .addrIn(ramAddr), .expIn(readExp),
    .rdata(ramRdata), .failFlag(failFlag), .failAddr(failAddr),
    .failExp(failExp), .failAct(failAct)
  );

endmodule

// File: rtl/mempat_engine_chk.sv
module mempat_engine_chk
  import mempat_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int TOP_BITS = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              ramEn,
  input logic              ramWr,
  input logic [ADDR_W-1:0] ramAddr,
  input logic [DATA_W-1:0] ramWdata,
  input logic              failFlag,
  input logic [ADDR_W-1:0] failAddr,
  input logic [DATA_W-1:0] failExp,
  input logic [DATA_W-1:0] failAct,
  input modeCode_t         activeMode
);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_quiet_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ramEn);

  p_mode_hold_r12: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(activeMode)));

  p_region_r8: assert property (@(posedge clk) disable iff (rst)
    (ramEn && activeMode == MODE_EDGE) |-> (&ramAddr[ADDR_W-1 -: TOP_BITS]));

  p_zero_fill_r3: assert property (@(posedge clk) disable iff (rst)
    (ramEn && ramWr && activeMode == MODE_ZERO) |-> (ramWdata == '0));

  p_fail_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && failFlag) |=> (failFlag && $stable(failAddr) &&
                            $stable(failExp) && $stable(failAct)));

endmodule

bind mempat_engine mempat_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOP_BITS(TOP_BITS)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .ramEn(ramEn),
  .ramWr(ramWr), .ramAddr(ramAddr), .ramWdata(ramWdata),
  .failFlag(failFlag), .failAddr(failAddr), .failExp(failExp),
  .failAct(failAct), .activeMode(activeMode)
);

// File: tb/sim_mempat_engine.sv
`timescale 1ns/1ps
module sim_mempat_engine;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int TOP_BITS = 3;
  localparam int DEPTH = 1 << ADDR_W;

  typedef struct packed {
    logic [3:0]  mode;
    logic        fOn;
    logic        fAll;
    logic [7:0]  fAddr;
    logic [2:0]  fBit;
    logic        fVal;
    logic        eFail;
    logic [7:0]  eAddr;
    logic [7:0]  eExp;
    logic [7:0]  eAct;
    logic [15:0] eLat;
    logic [15:0] eWr;
    logic [15:0] eRd;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{4'd0,1'b0,1'b0,8'd0, 3'd0,1'b0,1'b0,8'd0, 8'h00,8'h00,16'd130,16'd64, 16'd64},  // R2
    '{4'd0,1'b1,1'b1,8'd0, 3'd0,1'b1,1'b1,8'd0, 8'h00,8'h01,16'd130,16'd64, 16'd64},  // R2 R10
    '{4'd1,1'b1,1'b0,8'd5, 3'd3,1'b1,1'b1,8'd5, 8'h00,8'h08,16'd130,16'd64, 16'd64},  // R3
    '{4'd2,1'b0,1'b0,8'd0, 3'd0,1'b0,1'b0,8'd0, 8'h00,8'h00,16'd130,16'd64, 16'd64},  // R3
    '{4'd2,1'b1,1'b0,8'd63,3'd0,1'b0,1'b1,8'd63,8'hFF,8'hFE,16'd130,16'd64, 16'd64},  // R3
    '{4'd3,1'b0,1'b0,8'd0, 3'd0,1'b0,1'b0,8'd0, 8'h00,8'h00,16'd130,16'd64, 16'd64},  // R4
    '{4'd3,1'b1,1'b0,8'd10,3'd7,1'b1,1'b1,8'd10,8'h00,8'h80,16'd130,16'd64, 16'd64},  // R4
    '{4'd3,1'b1,1'b0,8'd11,3'd0,1'b0,1'b1,8'd11,8'hFF,8'hFE,16'd130,16'd64, 16'd64},  // R4
    '{4'd4,1'b1,1'b0,8'd2, 3'd1,1'b0,1'b1,8'd2, 8'h02,8'h00,16'd130,16'd64, 16'd64},  // R5
    '{4'd5,1'b0,1'b0,8'd0, 3'd0,1'b0,1'b0,8'd0, 8'h00,8'h00,16'd194,16'd128,16'd64},  // R6
    '{4'd5,1'b1,1'b0,8'd4, 3'd2,1'b0,1'b1,8'd4, 8'h04,8'h00,16'd194,16'd128,16'd64},  // R6
    '{4'd6,1'b0,1'b0,8'd0, 3'd0,1'b0,1'b0,8'd0, 8'h00,8'h00,16'd194,16'd64, 16'd128}, // R7
    '{4'd6,1'b1,1'b1,8'd0, 3'd7,1'b1,1'b1,8'd0, 8'h00,8'h80,16'd194,16'd64, 16'd128}, // R7
    '{4'd7,1'b0,1'b0,8'd0, 3'd0,1'b0,1'b0,8'd0, 8'h00,8'h00,16'd18, 16'd8,  16'd8},   // R8
    '{4'd7,1'b1,1'b0,8'd20,3'd0,1'b1,1'b0,8'd0, 8'h00,8'h00,16'd18, 16'd8,  16'd8},   // R8
    '{4'd7,1'b1,1'b0,8'd60,3'd4,1'b0,1'b1,8'd60,8'h3C,8'h2C,16'd18, 16'd8,  16'd8},   // R8
    '{4'd8,1'b0,1'b0,8'd0, 3'd0,1'b0,1'b0,8'd0, 8'h00,8'h00,16'd130,16'd64, 16'd64},  // R9
    '{4'd8,1'b1,1'b0,8'd9, 3'd1,1'b1,1'b1,8'd9, 8'hFD,8'hFF,16'd130,16'd64, 16'd64},  // R9
    '{4'd8,1'b1,1'b0,8'd2, 3'd2,1'b0,1'b1,8'd2, 8'h04,8'h00,16'd130,16'd64, 16'd64}   // R9
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0] modeSel = 4'd0;
  logic [ADDR_W-1:0] ramAddr;
  logic [DATA_W-1:0] ramWdata;
  logic ramEn, ramWr;
  logic [DATA_W-1:0] ramRdata = '0;
  logic busy, done, failFlag;
  logic [ADDR_W-1:0] failAddr;
  logic [DATA_W-1:0] failExp, failAct;

  always #10 clk = ~clk;

  mempat_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOP_BITS(TOP_BITS)) u0 (
    .clk(clk), .rst(rst), .start(start), .modeSel(modeSel),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .ramEn(ramEn), .ramWr(ramWr),
    .ramRdata(ramRdata), .busy(busy), .done(done), .failFlag(failFlag),
    .failAddr(failAddr), .failExp(failExp), .failAct(failAct)
  );

  // RAM companion with a single-bit fault injector
  logic [DATA_W-1:0] mem [DEPTH];
  logic       fOn = 1'b0, fAll = 1'b0, fVal = 1'b0;
  logic [7:0] fAddr = '0;
  logic [2:0] fBit = '0;

  always @(posedge clk) begin
    if (ramEn) begin
      if (ramWr) begin
        logic [DATA_W-1:0] w;
        w = ramWdata;
        if (fOn && (fAll || ramAddr == fAddr[ADDR_W-1:0])) w[fBit] = fVal;
        mem[ramAddr] <= w;
      end else begin
        ramRdata <= mem[ramAddr];
      end
    end
  end

  int nWr = 0, nRd = 0, minAddr = DEPTH;
  always @(negedge clk) begin
    if (ramEn) begin
      if (ramWr) nWr++; else nRd++;
      if (int'(ramAddr) < minAddr) minAddr = int'(ramAddr);
    end
  end

  int checks = 0, errors = 0, cycles = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [3:0] m);
    case (m)
      4'd0: return "R2";
      4'd1, 4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // pulse start on one edge, then count edges until done; optional mid-run restart
  task automatic runOnce(input logic [3:0] m, input int midStartAt,
                         input logic [3:0] midMode, output int lat);
    nWr = 0; nRd = 0; minAddr = DEPTH;
    @(negedge clk);
    modeSel = m; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 2000) begin
      if (lat == midStartAt) begin modeSel = midMode; start = 1'b1; end
      else start = 1'b0;
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
  endtask

  initial begin
    int lat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(!busy && !done && !failFlag && !ramEn, "R1", "reset outputs",
          {busy, done, failFlag, ramEn}, 0);
    rst = 1'b0;

    // R12: unsupported code does not start a run
    @(negedge clk);
    modeSel = 4'd9; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check(!busy && !done && nWr == 0 && nRd == 0, "R12", "code 9 ignored",
          {busy, done}, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string r;
      v = VECS[i];
      r = reqOf(v.mode);
      fOn = v.fOn; fAll = v.fAll; fAddr = v.fAddr; fBit = v.fBit; fVal = v.fVal;
      runOnce(v.mode, -1, 4'd0, lat);
      check(lat == int'(v.eLat), "R11", $sformatf("%s run length", r), lat, v.eLat);
      check(!busy, "R11", "busy low at done", busy, 0);
      check(nWr == int'(v.eWr), r, "write count", nWr, v.eWr);
      check(nRd == int'(v.eRd), r, "read count", nRd, v.eRd);
      check(failFlag == v.eFail, r, $sformatf("fail flag (R10) vec %0d", i), failFlag, v.eFail);
      if (v.eFail) begin
        check(failAddr == v.eAddr[ADDR_W-1:0], "R10", $sformatf("%s fail address", r), failAddr, v.eAddr);
        check(failExp == v.eExp, "R10", $sformatf("%s expected word", r), failExp, v.eExp);
        check(failAct == v.eAct, "R10", $sformatf("%s actual word", r), failAct, v.eAct);
      end
      if (v.mode == 4'd7)
        check(minAddr >= 56, "R8", "lowest address touched", minAddr, 56);
      @(negedge clk);
      check(!done, "R11", "done one cycle", done, 0);
    end
    fOn = 1'b0;

    // R12: start with another code during a run is ignored
    runOnce(4'd0, 10, 4'd7, lat);
    check(lat == 130, "R12", "restart ignored length", lat, 130);
    check(nWr == 64 && nRd == 64, "R12", "restart ignored accesses", nWr + nRd, 128);
    check(!failFlag, "R12", "restart ignored result", failFlag, 0);

    // R10: a failing run followed by a clean run leaves the record cleared
    fOn = 1'b1; fAll = 1'b0; fAddr = 8'd7; fBit = 3'd0; fVal = 1'b0;
    runOnce(4'd2, -1, 4'd0, lat);
    check(failFlag && failAddr == 6'd7, "R10", "fault seen", failAddr, 7);
    fOn = 1'b0;
    runOnce(4'd2, -1, 4'd0, lat);
    check(!failFlag && failAddr == '0, "R10", "cleared by next start", failFlag, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule